// File: doc/BRIEF.md
# Block Copy and Search Engine

This block is a sequencer for byte moves and byte searches over memory. It holds a source pointer, a destination pointer and a byte counter in 16-bit registers. Each step reads one byte at the source pointer. A copy step writes that byte to the destination pointer. A compare step checks the byte against an 8-bit accumulator value and writes nothing. After either step the pointers move forward or backward by one and the counter drops by one.

A caller loads the pointers, the counter, the incoming flag byte and the operation select, then pulses `start_i`. The engine runs either a single step or a repeating loop. A repeating copy runs until the counter is exhausted. A repeating compare runs until a byte matches or the counter is exhausted. When it finishes, the engine returns the updated registers and flags and raises a one-cycle done pulse.

Each iteration has a fixed minimum length in clock cycles. A step that loops again is longer than a single step or a final step. Memory waits can stretch an iteration beyond that minimum.

Top module: `blk_xfer_engine`

## Requirements
- R1: A copy step reads the byte at the source pointer and writes it at the destination pointer. Both pointers then change by +1 when `op_dec_i`=0, or by -1 when `op_dec_i`=1, and the counter decreases by 1.
- R2: A compare step reads the byte at the source pointer and makes no write access. Only the source pointer moves (by ±1), the destination pointer keeps its value, and the counter decreases by 1.
- R3: After every step, flag bit 2 (parity/overflow) is 0 if the decremented counter is zero and 1 otherwise.
- R4: After a compare step, bit 6 (zero) is 1 only when the accumulator equals the byte. Bit 7 (sign) is bit 7 of accumulator minus byte. Bit 4 (half) is 1 when the low nibble of the accumulator is below the low nibble of the byte. Bit 1 (subtract) is 1.
- R5: After a copy step, bits 4 and 1 are 0 and bits 7 and 6 keep their loaded values. In every operation, bits 5, 3 and 0 (carry) keep the values loaded from `flags_i`.
- R6: A repeating copy (`op_rep_i`=1) keeps stepping until the counter reaches zero.
- R7: A repeating compare stops after the first step whose byte matches the accumulator, or after the step that brings the counter to zero, whichever comes first.
- R8: With zero-wait memory, a single step or a final step lasts 16 cycles and a step that loops again lasts 21 cycles. The first step begins in the cycle after `start_i` is sampled.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last step ends. At that point `busy_o` is already low.
- R10: A counter loaded as zero wraps to 0xFFFF on its first decrement, and a repeating copy then continues to run.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: Each memory access completes only in a cycle with `mem_req_o` and `mem_rdy_i` both high. Wait cycles lengthen a step beyond its minimum length but do not change any result.
- R13: After reset, `busy_o`, `done_o` and `mem_req_o` are low, and the pointer, counter and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (used only when idle) |
| op_cmp_i | input | 1 | 1 = compare, 0 = copy |
| op_dec_i | input | 1 | 1 = pointers step down, 0 = up |
| op_rep_i | input | 1 | 1 = repeating, 0 = single step |
| acc_i | input | 8 | Accumulator value for compares |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial byte counter |
| flags_i | input | 8 | Incoming flag byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid when ready is high |
| mem_rdy_i | input | 1 | Access completes this cycle |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current counter |
| flags_o | output | 8 | Current flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Copies are run both upward and downward, single and repeating. Checking the written bytes, both pointers and the cycle count to done separates pointer direction, the loop length and the two iteration costs. Compares are run with a matching byte, with a mismatch whose nibbles borrow, with a repeating search that hits in the middle of a range and with one that exhausts its range; these tell the match stop apart from the count stop and exercise each flag rule. Further runs cover a counter loaded as zero, long memory waits, and a second start pulse sent during an operation, which show the wrap, the stretching and the ignored start.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_PAD} xfer_st_e;
  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;
endpackage

// File: rtl/blk_xfer_flags.sv
module blk_xfer_flags
  import blk_xfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          is_cmp_i,
  input  logic          cnt_nz_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] byte_i,
  input  logic [7:0]    flags_i,
  output logic [7:0]    flags_o
);
  localparam int NW = DW / 2;
  logic [DW:0] diff;

  always_comb begin
    diff    = {1'b0, acc_i} - {1'b0, byte_i};
    flags_o = flags_i;
    flags_o[FL_PV] = cnt_nz_i;
    if (is_cmp_i) begin
      flags_o[FL_S] = diff[DW-1];
      flags_o[FL_Z] = (acc_i == byte_i);
      flags_o[FL_H] = (acc_i[NW-1:0] < byte_i[NW-1:0]);
      flags_o[FL_N] = 1'b1;
    end else begin
      flags_o[FL_H] = 1'b0;
      flags_o[FL_N] = 1'b0;
    end
  end
endmodule

// File: rtl/blk_xfer_pace.sv
module blk_xfer_pace #(
  parameter int T_LAST = 16,
  parameter int T_LOOP = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic loop_i,
  output logic ok_o
);
  localparam int TMAX = (T_LOOP > T_LAST) ? T_LOOP : T_LAST;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LIM_LAST = CW'(T_LAST - 1);
  localparam logic [CW-1:0] LIM_LOOP = CW'(T_LOOP - 1);
  localparam logic [CW-1:0] LIM_SAT  = CW'(TMAX - 1);

  logic [CW-1:0] ic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ic_q <= '0;
    else if (clear_i)                 ic_q <= '0;
    else if (run_i && ic_q != LIM_SAT) ic_q <= ic_q + 1'b1;
  end

  assign ok_o = ic_q >= (loop_i ? LIM_LOOP : LIM_LAST);

  // R8: counter never runs past its saturation point
  a_r8_pace_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ic_q <= LIM_SAT);
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int T_LAST = 16,
  parameter int T_LOOP = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_cmp_i,
  input  logic          op_dec_i,
  input  logic          op_rep_i,
  input  logic [DW-1:0] acc_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [7:0]    flags_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] cnt_o,
  output logic [7:0]    flags_o,
  output logic          busy_o,
  output logic          done_o
);
  xfer_st_e      st_q;
  logic [AW-1:0] src_q, dst_q, cnt_q, cnt_nx, step;
  logic [DW-1:0] acc_q, byte_q;
  logic [7:0]    flg_q, flg_nx;
  logic          cmp_q, dec_q, rep_q, done_q;
  logic          launch, last, pace_ok, step_end;

  assign launch   = (st_q == ST_IDLE) && start_i;
  assign cnt_nx   = cnt_q - AW'(1);
  assign step     = dec_q ? {AW{1'b1}} : AW'(1);
  assign last     = !rep_q || (cnt_nx == '0) || (cmp_q && byte_q == acc_q);
  assign step_end = (st_q == ST_PAD) && pace_ok;

  blk_xfer_flags #(.DW(DW)) u_flags (
    .is_cmp_i (cmp_q),
    .cnt_nz_i (cnt_nx != '0),
    .acc_i    (acc_q),
    .byte_i   (byte_q),
    .flags_i  (flg_q),
    .flags_o  (flg_nx)
  );

  blk_xfer_pace #(.T_LAST(T_LAST), .T_LOOP(T_LOOP)) u_pace (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch || (step_end && !last)),
    .run_i   (st_q != ST_IDLE),
    .loop_i  (!last),
    .ok_o    (pace_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; flg_q <= '0;
      acc_q <= '0; byte_q <= '0;
      cmp_q <= 1'b0; dec_q <= 1'b0; rep_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          src_q <= src_i; dst_q <= dst_i; cnt_q <= cnt_i; flg_q <= flags_i;
          acc_q <= acc_i; cmp_q <= op_cmp_i; dec_q <= op_dec_i; rep_q <= op_rep_i;
          st_q  <= ST_RD;
        end
        ST_RD: if (mem_rdy_i) begin
          byte_q <= mem_rdata_i;
          st_q   <= cmp_q ? ST_PAD : ST_WR;
        end
        ST_WR: if (mem_rdy_i) st_q <= ST_PAD;
        ST_PAD: if (pace_ok) begin
          src_q <= src_q + step;
          if (!cmp_q) dst_q <= dst_q + step;
          cnt_q <= cnt_nx;
          flg_q <= flg_nx;
          if (last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata_o = byte_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign flags_o     = flg_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  a_r2_no_cmp_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && cmp_q) |-> !mem_we_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_end |=> cnt_q == AW'($past(cnt_q) - AW'(1)));
  a_r5_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> flags_o[FL_C] == $past(flags_o[FL_C]));
  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_end) |=> $stable(acc_q) && $stable(cmp_q) && $stable(src_q));
endmodule

// File: tb/blk_xfer_engine_tb.sv
module blk_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_cmp = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
  logic [7:0]  acc = '0, flg_in = '0;
  logic [15:0] src = '0, dst = '0, cnt = '0;
  logic        mem_req, mem_we, mem_rdy, busy, done;
  logic [15:0] mem_addr, src_o, dst_o, cnt_o;
  logic [7:0]  mem_wdata, mem_rdata, flg_o;

  logic [7:0]  mem [0:255];
  int          wait_cfg = 0, wcnt = 0, wr_count = 0;
  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = '0, tb_data = '0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  blk_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_cmp_i(op_cmp),
    .op_dec_i(op_dec), .op_rep_i(op_rep), .acc_i(acc), .src_i(src),
    .dst_i(dst), .cnt_i(cnt), .flags_i(flg_in), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy), .src_o(src_o),
    .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flg_o), .busy_o(busy),
    .done_o(done)
  );

  assign mem_rdy   = mem_req && (wcnt == wait_cfg);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_req) begin
      if (mem_rdy) begin
        wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          wr_count <= wr_count + 1;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic go(input bit c, input bit dn, input bit r, input logic [7:0] a,
                    input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                    input logic [7:0] f);
    @(negedge clk);
    op_cmp = c; op_dec = dn; op_rep = r; acc = a; src = s; dst = d; cnt = n; flg_in = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 1;
    while (!done && k < 3000) begin
      @(negedge clk); k++;
    end
    chk(done, "R9 done seen", {31'b0, done}, 32'd1);
    eq("R9 busy low at done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    eq("R9 done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    eq("R13 busy", {31'b0, busy}, 0);
    eq("R13 done", {31'b0, done}, 0);
    eq("R13 req", {31'b0, mem_req}, 0);
    eq("R13 regs", {src_o | dst_o | cnt_o, 8'h00, flg_o}, 0);
  endtask

  task automatic t_copy_single_inc;
    int k;
    poke(8'h10, 8'hA5);
    go(0, 0, 0, 8'h00, 16'h0010, 16'h0040, 16'd3, 8'hFF);
    wait_done(k);
    eq("R8 single cycles", k, 17);
    eq("R1 written byte", mem[8'h40], 8'hA5);
    eq("R1 src", src_o, 16'h0011);
    eq("R1 dst", dst_o, 16'h0041);
    eq("R1 cnt", cnt_o, 16'd2);
    eq("R5 R3 copy flags", flg_o, 8'hED); // H,N cleared, rest kept, PV=1
  endtask

  task automatic t_copy_single_dec;
    int k;
    poke(8'h20, 8'h3C);
    go(0, 1, 0, 8'h00, 16'h0020, 16'h0050, 16'd1, 8'h00);
    wait_done(k);
    eq("R1 dec written", mem[8'h50], 8'h3C);
    eq("R1 dec src", src_o, 16'h001F);
    eq("R1 dec dst", dst_o, 16'h004F);
    eq("R3 pv zero", flg_o, 8'h00);
  endtask

  task automatic t_copy_repeat;
    int k;
    for (int i = 0; i < 4; i++) poke(8'h60 + 8'(i), 8'(i + 1));
    go(0, 0, 1, 8'h00, 16'h0060, 16'h0080, 16'd4, 8'h01);
    wait_done(k);
    eq("R8 loop cycles", k, 21 * 3 + 16 + 1);
    for (int i = 0; i < 4; i++) eq("R6 copied byte", mem[8'h80 + 8'(i)], 32'(i + 1));
    eq("R6 src", src_o, 16'h0064);
    eq("R6 dst", dst_o, 16'h0084);
    eq("R6 cnt", cnt_o, 16'd0);
    eq("R5 carry kept", flg_o, 8'h01);
  endtask

  task automatic t_cmp_match;
    int k, w0;
    poke(8'h90, 8'h30);
    w0 = wr_count;
    go(1, 0, 0, 8'h30, 16'h0090, 16'h0077, 16'd5, 8'h01);
    wait_done(k);
    eq("R8 cmp cycles", k, 17);
    eq("R2 no write", wr_count, w0);
    eq("R2 src", src_o, 16'h0091);
    eq("R2 dst kept", dst_o, 16'h0077);
    eq("R2 cnt", cnt_o, 16'd4);
    eq("R4 match flags", flg_o, 8'h47);
  endtask

  task automatic t_cmp_mismatch;
    int k;
    poke(8'hA0, 8'h21);
    go(1, 1, 0, 8'h10, 16'h00A0, 16'h0033, 16'd1, 8'h00);
    wait_done(k);
    eq("R2 dec src", src_o, 16'h009F);
    eq("R4 mismatch flags", flg_o, 8'h92); // S,H,N set; Z,PV clear
  endtask

  task automatic t_cmp_rep_hit;
    int k;
    for (int i = 0; i < 5; i++) poke(8'hB0 + 8'(i), 8'(i + 5));
    go(1, 0, 1, 8'h07, 16'h00B0, 16'h0000, 16'd10, 8'h00);
    wait_done(k);
    eq("R7 hit cycles", k, 21 * 2 + 16 + 1);
    eq("R7 hit src", src_o, 16'h00B3);
    eq("R7 hit cnt", cnt_o, 16'd7);
    eq("R7 hit flags", flg_o, 8'h46);
  endtask

  task automatic t_cmp_rep_exhaust;
    int k;
    for (int i = 0; i < 3; i++) poke(8'hC0 + 8'(i), 8'(i + 1));
    go(1, 1, 1, 8'hFF, 16'h00C2, 16'h0000, 16'd3, 8'h00);
    wait_done(k);
    eq("R7 exhaust cycles", k, 21 * 2 + 16 + 1);
    eq("R7 exhaust src", src_o, 16'h00BF);
    eq("R7 exhaust cnt", cnt_o, 16'd0);
    eq("R7 R4 exhaust flags", flg_o, 8'h82);
  endtask

  task automatic t_cnt_zero_single;
    int k;
    go(0, 0, 0, 8'h00, 16'h0005, 16'h0006, 16'd0, 8'h00);
    wait_done(k);
    eq("R10 wrapped cnt", cnt_o, 16'hFFFF);
    eq("R10 pv set", flg_o, 8'h04);
  endtask

  task automatic t_waits;
    int k;
    poke(8'h11, 8'h5E);
    wait_cfg = 10;
    go(0, 0, 0, 8'h00, 16'h0011, 16'h0044, 16'd2, 8'h00);
    wait_done(k);
    wait_cfg = 0;
    eq("R12 stretched cycles", k, 24);
    eq("R12 written byte", mem[8'h44], 8'h5E);
    eq("R12 src", src_o, 16'h0012);
    eq("R12 cnt", cnt_o, 16'd1);
  endtask

  task automatic t_start_ignored;
    int k;
    poke(8'h70, 8'hC1);
    poke(8'h71, 8'hC2);
    go(0, 0, 1, 8'h00, 16'h0070, 16'h00D0, 16'd2, 8'h00);
    k = 1;
    repeat (4) begin @(negedge clk); k++; end
    op_cmp = 1'b1; src = 16'h00F0; cnt = 16'd9; start = 1'b1;
    @(negedge clk); k++;
    start = 1'b0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    eq("R11 cycles unchanged", k, 21 + 16 + 1);
    eq("R11 bytes copied", {mem[8'hD0], mem[8'hD1]}, 16'hC1C2);
    eq("R11 src", src_o, 16'h0072);
    eq("R11 cnt", cnt_o, 16'd0);
  endtask

  task automatic t_repeat_wrap;
    go(0, 0, 1, 8'h00, 16'h0030, 16'h0090, 16'd0, 8'h00);
    repeat (24) @(negedge clk);
    eq("R10 still busy", {31'b0, busy}, 1);
    eq("R10 cnt wrapped", cnt_o, 16'hFFFF);
    eq("R10 src advanced", src_o, 16'h0031);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    wait (cyc == 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_copy_single_inc();
    t_copy_single_dec();
    t_copy_repeat();
    t_cmp_match();
    t_cmp_mismatch();
    t_cmp_rep_hit();
    t_cmp_rep_exhaust();
    t_cnt_zero_single();
    t_waits();
    t_start_ignored();
    t_repeat_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule